// File: doc/BRIEF.md
# HDLC Supervisory Frame Event Detector

This block sits behind an HDLC receiver that has already found flags, removed stuffed bits and checked the CRC. At the end of each frame the receiver hands over one item on a valid/ready stream: the control octet, a flag saying whether an information field followed it, and a flag marking a frame that failed CRC or was aborted. The transmit side supplies two sequence numbers: the oldest frame not yet acknowledged by the peer and the next number it will send. Together they set the range of acknowledgement numbers, N(R), that a received frame may carry.

While the automatic link-layer mode is enabled, the block tracks whether the peer's receiver is ready. It changes that state only when an RR or RNR supervisory frame actually reverses it. It also raises two sticky interrupt bits. One marks a change in peer readiness. The other marks a protocol error: an N(R) outside the allowed range, or a supervisory frame that carries an information field. Software clears both bits with a single read strobe.

The stream has no back-pressure. `frm_ready` rises in the first cycle after reset and then stays high. An item is taken on every rising clock edge where `frm_valid` and `frm_ready` are both high. The source may hold `frm_valid` high for several cycles, but each such cycle is counted as a separate frame.

Top module: `hdlc_sframe_evt`

## Requirements
- R1: `frm_ready` is high in every cycle after the first cycle following reset and never drops. An item is accepted on a rising edge with `frm_valid` and `frm_ready` both high. Its effect on `peer_rdy` and the interrupt bits is visible right after that same edge.
- R2: The control octet is classified by its low bits. Bit 0 = 0 is an I-frame. Bits 1:0 = 01 is an S-frame. Bits 1:0 = 11 is a U-frame, which is ignored. For an S-frame, bits 3:2 give the kind: 00 = RR, 01 = RNR, 10 and 11 are other kinds that never change readiness. For I- and S-frames, N(R) is bits 7:5.
- R3: An accepted RR frame with no protocol error, arriving while `peer_rdy` is 0, sets `peer_rdy` to 1 and sets `evt_peer_chg`.
- R4: An accepted RNR frame with no protocol error, arriving while `peer_rdy` is 1, sets `peer_rdy` to 0 and sets `evt_peer_chg`.
- R5: An RR frame while `peer_rdy` is 1, or an RNR frame while `peer_rdy` is 0, changes neither `peer_rdy` nor `evt_peer_chg`.
- R6: An I- or S-frame sets `evt_proto_err` unless (N(R) − `ack_seq`) mod 8 ≤ (`nxt_seq` − `ack_seq`) mod 8. Both ends of that range are valid, and the range may wrap past 7.
- R7: An S-frame accepted with `frm_info` = 1 sets `evt_proto_err`.
- R8: A frame that raises a protocol error leaves `peer_rdy` unchanged.
- R9: An item with `frm_bad` = 1 changes neither `peer_rdy` nor the interrupt bits.
- R10: While `auto_en` is 0, accepted items change neither `peer_rdy` nor the interrupt bits.
- R11: After reset `peer_rdy` is 1 and both interrupt bits are 0.
- R12: Each interrupt bit stays set until a cycle with `stat_rd` high, which clears it at that edge. If a new event for that bit arrives on the same edge, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_en | input | 1 | Automatic link-layer mode enable |
| frm_valid | input | 1 | End-of-frame item valid |
| frm_ready | output | 1 | Item accepted when high together with frm_valid |
| frm_ctrl | input | 8 | Received control octet |
| frm_info | input | 1 | An information field followed the control octet |
| frm_bad | input | 1 | Frame had a CRC error or was aborted |
| ack_seq | input | 3 | Oldest sequence number not yet acknowledged |
| nxt_seq | input | 3 | Next send sequence number |
| stat_rd | input | 1 | Status read strobe; clears both interrupt bits |
| evt_peer_chg | output | 1 | Sticky peer-readiness change interrupt |
| evt_proto_err | output | 1 | Sticky protocol error interrupt |
| peer_rdy | output | 1 | Current peer receiver readiness |

## Verification
RR and RNR frames are sent in both peer states. Comparing the two cases separates a real readiness change from a repeated one. The N(R) check uses a window that does not wrap and one that wraps past 7, with N(R) placed on each edge of the window and just outside it, so off-by-one and wrap errors show up. REJ-kind and U-frames with out-of-range N(R), an RNR that carries an information field, bad frames, and frames sent with the mode off each show whether the error path and the state path are gated correctly. A read that coincides with a new event shows whether set takes priority over clear.

// File: rtl/hdlc_sev_pkg.sv
package hdlc_sev_pkg;

  typedef enum logic [1:0] {
    FC_INFO = 2'd0,
    FC_SUP  = 2'd1,
    FC_UNN  = 2'd2
  } frame_class_e;

  typedef enum logic [1:0] {
    SK_RR   = 2'b00,
    SK_RNR  = 2'b01,
    SK_REJ  = 2'b10,
    SK_SREJ = 2'b11
  } sup_kind_e;

  function automatic frame_class_e classify(input logic [1:0] low_bits);
    if (!low_bits[0])
      return FC_INFO;
    else if (low_bits == 2'b01)
      return FC_SUP;
    else
      return FC_UNN;
  endfunction

endpackage

// File: rtl/sev_frame_decode.sv
module sev_frame_decode
  import hdlc_sev_pkg::*;
#(
  parameter int CTRL_W = 8,
  parameter int SEQ_W  = 3
) (
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              has_info,
  input  logic [SEQ_W-1:0]  ack_seq,
  input  logic [SEQ_W-1:0]  nxt_seq,
  output logic              is_rr,
  output logic              is_rnr,
  output logic              proto_err
);

  localparam int NR_LSB = CTRL_W - SEQ_W;

  frame_class_e      cls;
  sup_kind_e         kind;
  logic [SEQ_W-1:0]  nr;
  logic [SEQ_W-1:0]  dist_nr;
  logic [SEQ_W-1:0]  dist_win;
  logic              in_win;
  logic              nr_err;
  logic              info_err;

  always_comb begin
    cls      = classify(ctrl[1:0]);
    kind     = sup_kind_e'(ctrl[3:2]);
    nr       = ctrl[CTRL_W-1:NR_LSB];
    dist_nr  = nr - ack_seq;
    dist_win = nxt_seq - ack_seq;
    in_win   = (dist_nr <= dist_win);
    nr_err   = (cls != FC_UNN) && !in_win;
    info_err = (cls == FC_SUP) && has_info;
    proto_err = nr_err || info_err;
    is_rr    = (cls == FC_SUP) && (kind == SK_RR);
    is_rnr   = (cls == FC_SUP) && (kind == SK_RNR);
  end

endmodule

// File: rtl/sev_peer_tracker.sv
module sev_peer_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic is_rr,
  input  logic is_rnr,
  input  logic proto_err,
  output logic peer_rdy,
  output logic chg_pulse
);

  logic clean;

  always_comb begin
    clean     = take && !proto_err;
    chg_pulse = clean && ((is_rr && !peer_rdy) || (is_rnr && peer_rdy));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      peer_rdy <= 1'b1;
    else if (chg_pulse)
      peer_rdy <= !peer_rdy;
  end

  a_r3_rr_leaves_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_rr && !proto_err) |=> peer_rdy);

  a_r4_rnr_leaves_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_rnr && !proto_err) |=> !peer_rdy);

  a_r8_error_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (take && proto_err) |=> $stable(peer_rdy));

endmodule

// File: rtl/sev_sticky_irq.sv
module sev_sticky_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         rd,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)
        q[i] <= 1'b0;
      else if (set[i])
        q[i] <= 1'b1;
      else if (rd)
        q[i] <= 1'b0;
    end

    a_r12_hold_until_read: assert property (@(posedge clk) disable iff (!rst_n)
      (q[i] && !rd) |=> q[i]);

    a_r12_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q[i]) |-> $past(set[i]));
  end

endmodule

// File: rtl/hdlc_sframe_evt.sv
module hdlc_sframe_evt #(
  parameter int CTRL_W = 8,
  parameter int SEQ_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_en,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [CTRL_W-1:0] frm_ctrl,
  input  logic              frm_info,
  input  logic              frm_bad,
  input  logic [SEQ_W-1:0]  ack_seq,
  input  logic [SEQ_W-1:0]  nxt_seq,
  input  logic              stat_rd,
  output logic              evt_peer_chg,
  output logic              evt_proto_err
  ,output logic             peer_rdy
);

  localparam int N_IRQ   = 2;
  localparam int IRQ_CHG = 0;
  localparam int IRQ_ERR = 1;

  logic             take;
  logic             is_rr;
  logic             is_rnr;
  logic             proto_err;
  logic             chg_pulse;
  logic [N_IRQ-1:0] irq_set;
  logic [N_IRQ-1:0] irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      frm_ready <= 1'b0;
    else
      frm_ready <= 1'b1;
  end

  assign take = frm_valid && frm_ready && auto_en && !frm_bad;

  sev_frame_decode #(.CTRL_W(CTRL_W), .SEQ_W(SEQ_W)) u_dec (
    .ctrl      (frm_ctrl),
    .has_info  (frm_info),
    .ack_seq   (ack_seq),
    .nxt_seq   (nxt_seq),
    .is_rr     (is_rr),
    .is_rnr    (is_rnr),
    .proto_err (proto_err)
  );

  sev_peer_tracker u_peer (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .is_rr     (is_rr),
    .is_rnr    (is_rnr),
    .proto_err (proto_err),
    .peer_rdy  (peer_rdy),
    .chg_pulse (chg_pulse)
  );

  always_comb begin
    irq_set          = '0;
    irq_set[IRQ_CHG] = chg_pulse;
    irq_set[IRQ_ERR] = take && proto_err;
  end

  sev_sticky_irq #(.N(N_IRQ)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (irq_set),
    .rd    (stat_rd),
    .q     (irq_q)
  );

  assign evt_peer_chg  = irq_q[IRQ_CHG];
  assign evt_proto_err = irq_q[IRQ_ERR];

  a_r1_ready_never_drops: assert property (@(posedge clk) disable iff (!rst_n)
    frm_ready |=> frm_ready);

  a_r10_mode_off_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en && !stat_rd) |=>
      ($stable(peer_rdy) && $stable(evt_peer_chg) && $stable(evt_proto_err)));

  a_r9_bad_frame_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_bad && !stat_rd) |=>
      ($stable(peer_rdy) && $stable(evt_peer_chg) && $stable(evt_proto_err)));

  a_r7_sup_with_info_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready && auto_en && !frm_bad && frm_info &&
     frm_ctrl[1:0] == 2'b01) |=> evt_proto_err);

  a_r5_idle_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_valid && frm_ready) |=> $stable(peer_rdy));

endmodule

// File: tb/tb_hdlc_sframe_evt.sv
module tb_hdlc_sframe_evt;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       auto_en = 1'b0;
  logic       frm_valid = 1'b0;
  logic       frm_ready;
  logic [7:0] frm_ctrl = '0;
  logic       frm_info = 1'b0;
  logic       frm_bad = 1'b0;
  logic [2:0] ack_seq = '0;
  logic [2:0] nxt_seq = '0;
  logic       stat_rd = 1'b0;
  logic       evt_peer_chg;
  logic       evt_proto_err;
  logic       peer_rdy;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  logic m_chg = 1'b0;
  logic m_err = 1'b0;
  logic m_rdy = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_sframe_evt dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .auto_en       (auto_en),
    .frm_valid     (frm_valid),
    .frm_ready     (frm_ready),
    .frm_ctrl      (frm_ctrl),
    .frm_info      (frm_info),
    .frm_bad       (frm_bad),
    .ack_seq       (ack_seq),
    .nxt_seq       (nxt_seq),
    .stat_rd       (stat_rd),
    .evt_peer_chg  (evt_peer_chg),
    .evt_proto_err (evt_proto_err),
    .peer_rdy      (peer_rdy)
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {chg,err,rdy} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Monitor: pops one expected item per cycle after the driver's edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {evt_peer_chg, evt_proto_err, peer_rdy}, e);
    end
  end

  // Driver: one cycle, updates the reference model, pushes the expectation
  task automatic step(input logic v, input logic [7:0] c, input logic info,
                      input logic bad, input logic mode, input logic [2:0] va,
                      input logic [2:0] vs, input logic rd, input string tag);
    logic tk, is_i, is_s, err, win, s_chg, s_err;
    logic [2:0] nr;
    @(negedge clk);
    frm_valid = v; frm_ctrl = c; frm_info = info; frm_bad = bad;
    auto_en = mode; ack_seq = va; nxt_seq = vs; stat_rd = rd;
    tk   = v && mode && !bad;
    is_i = (c[0] == 1'b0);
    is_s = (c[1:0] == 2'b01);
    nr   = c[7:5];
    win  = (3'(nr - va) <= 3'(vs - va));
    err  = (is_i || is_s) && (!win || (is_s && info));
    s_chg = 1'b0;
    s_err = tk && err;
    if (tk && !err && is_s) begin
      if (c[3:2] == 2'b00 && !m_rdy) begin m_rdy = 1'b1; s_chg = 1'b1; end
      else if (c[3:2] == 2'b01 && m_rdy) begin m_rdy = 1'b0; s_chg = 1'b1; end
    end
    if (rd) begin m_chg = 1'b0; m_err = 1'b0; end
    if (s_chg) m_chg = 1'b1;
    if (s_err) m_err = 1'b1;
    @(posedge clk);
    #1;
    exp_q.push_back({m_chg, m_err, m_rdy});
    tag_q.push_back(tag);
  endtask

  // helpers: control octets with N(R) in bits 7:5
  function automatic logic [7:0] s_rr(input logic [2:0] n);  return {n, 5'b00001}; endfunction
  function automatic logic [7:0] s_rnr(input logic [2:0] n); return {n, 5'b00101}; endfunction
  function automatic logic [7:0] s_rej(input logic [2:0] n); return {n, 5'b01001}; endfunction
  function automatic logic [7:0] i_frm(input logic [2:0] n); return {n, 5'b00000}; endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", {evt_peer_chg, evt_proto_err, peer_rdy}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    n_cmp++;
    if (frm_ready !== 1'b1) begin n_bad++; $display("FAIL R1: frm_ready actual=%b expected=1", frm_ready); end

    step(1, s_rr(3'd3), 0, 0, 1, 3'd2, 3'd5, 0, "R5 RR while ready");
    step(1, s_rnr(3'd2), 0, 0, 1, 3'd2, 3'd5, 0, "R4 RNR while ready");
    step(0, 8'h00, 0, 0, 1, 3'd2, 3'd5, 1, "R12 read clears");
    step(1, s_rnr(3'd5), 0, 0, 1, 3'd2, 3'd5, 0, "R5 RNR while not ready");
    step(1, s_rr(3'd4), 0, 0, 1, 3'd2, 3'd5, 0, "R3 RR while not ready");
    step(0, 8'h00, 0, 0, 1, 3'd2, 3'd5, 0, "R12 bit held without read");
    step(0, 8'h00, 0, 0, 1, 3'd2, 3'd5, 1, "R12 read clears");
    step(1, i_frm(3'd6), 1, 0, 1, 3'd2, 3'd5, 0, "R6 I-frame N(R) above window");
    step(0, 8'h00, 0, 0, 1, 3'd2, 3'd5, 1, "R12 read");
    step(1, i_frm(3'd1), 1, 0, 1, 3'd2, 3'd5, 0, "R6 I-frame N(R) below window");
    step(0, 8'h00, 0, 0, 1, 3'd2, 3'd5, 1, "R12 read");
    step(1, s_rnr(3'd3), 1, 0, 1, 3'd2, 3'd5, 0, "R7 R8 RNR with info field");
    step(0, 8'h00, 0, 0, 1, 3'd2, 3'd5, 1, "R12 read");
    step(1, s_rnr(3'd7), 0, 0, 1, 3'd2, 3'd5, 0, "R8 RNR out of window");
    step(0, 8'h00, 0, 0, 1, 3'd2, 3'd5, 1, "R12 read");
    step(1, s_rnr(3'd3), 0, 1, 1, 3'd2, 3'd5, 0, "R9 bad frame ignored");
    step(1, s_rnr(3'd7), 1, 1, 1, 3'd2, 3'd5, 0, "R9 bad erroneous frame ignored");
    step(1, s_rnr(3'd3), 0, 0, 0, 3'd2, 3'd5, 0, "R10 mode off RNR");
    step(1, i_frm(3'd7), 0, 0, 0, 3'd2, 3'd5, 0, "R10 mode off bad N(R)");
    step(1, 8'hFF, 1, 0, 1, 3'd2, 3'd5, 0, "R2 U-frame ignored");
    step(1, s_rej(3'd0), 0, 0, 1, 3'd2, 3'd5, 0, "R2 R6 REJ out of window");
    step(0, 8'h00, 0, 0, 1, 3'd2, 3'd5, 1, "R12 read");
    step(1, s_rej(3'd2), 0, 0, 1, 3'd2, 3'd5, 0, "R2 REJ in window no change");
    // wrapping window ack=6, nxt=1 : valid 6,7,0,1
    step(1, s_rnr(3'd6), 0, 0, 1, 3'd6, 3'd1, 0, "R6 low edge of wrapped window");
    step(1, s_rr(3'd1), 0, 0, 1, 3'd6, 3'd1, 1, "R6 R12 high edge, read with event");
    step(0, 8'h00, 0, 0, 1, 3'd6, 3'd1, 1, "R12 read");
    step(1, s_rr(3'd2), 0, 0, 1, 3'd6, 3'd1, 0, "R6 just past wrapped window");
    step(1, s_rnr(3'd0), 0, 0, 1, 3'd6, 3'd1, 1, "R6 R12 wrapped middle, read with event");
    step(1, s_rr(3'd5), 0, 0, 1, 3'd6, 3'd1, 0, "R6 just before wrapped window");
    step(1, i_frm(3'd7), 1, 0, 1, 3'd6, 3'd1, 1, "R6 I-frame wrapped valid");
    step(1, s_rr(3'd4), 0, 0, 1, 3'd4, 3'd4, 0, "R6 empty window N(R) equals both");
    step(0, 8'h00, 0, 0, 1, 3'd4, 3'd4, 0, "R1 idle cycle");
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule